// File: doc/BRIEF.md
# Matrix Key Snapshot Event Differ

This block takes one snapshot of the keys a matrix scanner currently reports as down and turns it into an ordered stream of key events. A snapshot holds a fixed number of slots. Each slot carries a valid flag, a row number and a column number. Slots whose valid flag is clear are skipped. The valid slots are packed into a list of scan codes in slot order.

Before the list reaches the comparison stage, two optional filters run. In function-layer mode, the configured function key is removed from the list, and every other code in that snapshot is moved up by the matrix size into a second code page. With the ghost filter enabled, a snapshot that shows the row/column pattern typical of phantom keys is discarded whole.

A snapshot that survives both filters is compared with the key set accepted last time. The block sends a release for each key that has gone, then a press for every key now held, then a sync beat. A separate request releases every held key at once. Events leave through a valid/ready stream, one event per transfer.

Top module: `key_event_differ`

## Requirements
- R1: A key at row r and column c has scan code r*8+c: row in bits [6:3], column in bits [2:0], bit 7 clear. Codes keep the slot order of the snapshot, and slots whose valid flag is clear are skipped without ending the list.
- R2: With function-layer mode on, every valid slot whose code equals `fn_code` is dropped. If at least one was dropped, 128 (rows × columns) is added to every other code of that snapshot.
- R3: With function-layer mode off, a slot whose code equals `fn_code` is reported like any other key.
- R4: With the ghost filter on and at least three keys in the list, the snapshot is rejected when one pair of keys shares a column and one pair (possibly another pair) shares a row. A rejected snapshot is consumed, yields no events and no sync beat, and leaves the stored key set unchanged.
- R5: With the ghost filter off, or with fewer than three keys, or with shared rows but no shared column, the snapshot is accepted.
- R6: For an accepted snapshot, a release event (press bit 0, sync 0) is sent for each stored code absent from the new list, in stored order. All releases come before any press.
- R7: After the releases, a press event (press bit 1) is sent for every code in the new list, in list order. Then one sync beat is sent (sync 1, press 0, code 0).
- R8: After the sync beat of an accepted snapshot, the stored key set and its count are the new list.
- R9: A `rel_all` pulse seen while idle sends a release for every stored code, then a sync beat, and leaves the stored set empty. In a cycle where `rel_all` is high, `snap_ready` is low, so a snapshot offered in the same cycle waits until the release sequence is complete.
- R10: While `ev_valid` is high and `ev_ready` is low, the event fields hold steady. `snap_ready` is high only while idle, and no event is offered while idle.
- R11: After reset the stored set is empty, the block is idle with `snap_ready` high, and `ev_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_mode_en | input | 1 | Function-layer mode enable |
| fn_code | input | 8 | Scan code of the function key |
| ghost_en | input | 1 | Ghost filter enable |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Snapshot taken at this edge when snap_valid is high |
| snap_vld | input | 8 | Per-slot valid flags |
| snap_row | input | 32 | Per-slot row number, 4 bits per slot, slot 0 lowest |
| snap_col | input | 24 | Per-slot column number, 3 bits per slot, slot 0 lowest |
| rel_all | input | 1 | Release every stored key (acted on while idle) |
| ev_valid | output | 1 | Event offered |
| ev_ready | input | 1 | Event consumer ready |
| ev_press | output | 1 | 1 for a press, 0 for a release or sync |
| ev_sync | output | 1 | End-of-snapshot marker beat |
| ev_code | output | 8 | Scan code of the event |

## Verification
The release-all request and a snapshot offer can arrive in the same idle cycle. The bench raises both together and checks that `snap_ready` is low at once. It then keeps the snapshot offered and expects the stream to hold the release-all releases and their sync beat first, followed by the snapshot's presses and a second sync beat. The same bench model also follows function-key shifting, which can produce a release and a press for the same physical key in one snapshot.

// File: rtl/kef_pkg.sv
package kef_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REL  = 2'd1,
    ST_PRS  = 2'd2,
    ST_SYNC = 2'd3
  } seq_state_t;
endpackage

// File: rtl/kef_snap_decode.sv
module kef_snap_decode #(
  parameter int NUM_ENT = 8,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 3,
  parameter int CODE_W  = 8,
  parameter int KEY_CNT = 128,
  parameter int CNT_W   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_ENT-1:0]                ent_vld,
  input  logic [NUM_ENT*ROW_W-1:0]          ent_row,
  input  logic [NUM_ENT*COL_W-1:0]          ent_col,
  input  logic                              fn_en,
  input  logic [CODE_W-1:0]                 fn_code,
  output logic [NUM_ENT-1:0][CODE_W-1:0]    codes,
  output logic [CNT_W-1:0]                  cnt,
  output logic                              fn_hit
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  // Pack valid slots in order; drop function key and shift the page.
  always_comb begin
    logic [CODE_W-1:0] raw;
    codes  = '0;
    cnt    = '0;
    fn_hit = 1'b0;
    for (int k = 0; k < NUM_ENT; k++) begin
      raw = CODE_W'({ent_row[k*ROW_W +: ROW_W], ent_col[k*COL_W +: COL_W]});
      if (ent_vld[k]) begin
        if (fn_en && (raw == fn_code)) begin
          fn_hit = 1'b1;
        end else begin
          codes[cnt[IDX_W-1:0]] = raw;
          cnt = cnt + CNT_W'(1);
        end
      end
    end
    if (fn_hit) begin
      for (int k = 0; k < NUM_ENT; k++) begin
        if (CNT_W'(k) < cnt) codes[k] = codes[k] + CODE_W'(KEY_CNT);
      end
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'($countones(ent_vld)));

  p_fn_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fn_hit |-> (fn_en && (cnt < CNT_W'($countones(ent_vld)))));
endmodule

// File: rtl/kef_ghost_check.sv
module kef_ghost_check #(
  parameter int NUM_ENT = 8,
  parameter int COL_W   = 3,
  parameter int CODE_W  = 8,
  parameter int CNT_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic [NUM_ENT-1:0][CODE_W-1:0] codes,
  input  logic [CNT_W-1:0]               cnt,
  output logic                           ghost
);
  logic share_col, share_row;

  always_comb begin
    share_col = 1'b0;
    share_row = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      for (int j = i + 1; j < NUM_ENT; j++) begin
        if (CNT_W'(j) < cnt) begin
          if (codes[i][COL_W-1:0] == codes[j][COL_W-1:0]) share_col = 1'b1;
          if (codes[i][CODE_W-1:COL_W] == codes[j][CODE_W-1:COL_W]) share_row = 1'b1;
        end
      end
    end
    ghost = en && (cnt >= CNT_W'(3)) && share_col && share_row;
  end

  p_ghost_min_keys_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ghost |-> (en && (cnt > CNT_W'(2))));
endmodule

// File: rtl/kef_event_seq.sv
module kef_event_seq
  import kef_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int CODE_W  = 8,
  parameter int CNT_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           snap_valid,
  input  logic                           rel_all,
  input  logic [NUM_ENT-1:0][CODE_W-1:0] dec_codes,
  input  logic [CNT_W-1:0]               dec_cnt,
  input  logic                           ghost,
  output logic                           snap_ready,
  output logic                           ev_valid,
  input  logic                           ev_ready,
  output logic                           ev_press,
  output logic                           ev_sync,
  output logic [CODE_W-1:0]              ev_code
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  seq_state_t                     state_q, state_d;
  logic [CNT_W-1:0]               idx_q, idx_d;
  logic [NUM_ENT-1:0][CODE_W-1:0] prev_q, new_q;
  logic [CNT_W-1:0]               prev_cnt_q, new_cnt_q, new_cnt_d;
  logic                           new_en, prev_en, idle;
  logic                           rel_more, prs_more, in_new;
  logic [CODE_W-1:0]              cur_prev, cur_new;

  assign idle       = (state_q == ST_IDLE);
  assign snap_ready = idle && !rel_all;
  assign rel_more   = idx_q < prev_cnt_q;
  assign prs_more   = idx_q < new_cnt_q;
  assign cur_prev   = prev_q[idx_q[IDX_W-1:0]];
  assign cur_new    = new_q[idx_q[IDX_W-1:0]];

  // Is the stored key under the cursor still held in the new list?
  always_comb begin
    in_new = 1'b0;
    for (int k = 0; k < NUM_ENT; k++) begin
      if ((CNT_W'(k) < new_cnt_q) && (new_q[k] == cur_prev)) in_new = 1'b1;
    end
  end

  always_comb begin
    ev_valid = 1'b0;
    ev_press = 1'b0;
    ev_sync  = 1'b0;
    ev_code  = '0;
    unique case (state_q)
      ST_REL: begin
        ev_valid = rel_more && !in_new;
        ev_code  = cur_prev;
      end
      ST_PRS: begin
        ev_valid = prs_more;
        ev_press = 1'b1;
        ev_code  = cur_new;
      end
      ST_SYNC: begin
        ev_valid = 1'b1;
        ev_sync  = 1'b1;
      end
      default: ;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    new_cnt_d = new_cnt_q;
    new_en    = 1'b0;
    prev_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rel_all) begin
          new_cnt_d = '0;
          idx_d     = '0;
          state_d   = ST_REL;
        end else if (snap_valid && !ghost) begin
          new_en    = 1'b1;
          new_cnt_d = dec_cnt;
          idx_d     = '0;
          state_d   = ST_REL;
        end
      end
      ST_REL: begin
        if (!rel_more) begin
          idx_d   = '0;
          state_d = ST_PRS;
        end else if (in_new || ev_ready) begin
          idx_d = idx_q + CNT_W'(1);
        end
      end
      ST_PRS: begin
        if (!prs_more) begin
          state_d = ST_SYNC;
        end else if (ev_ready) begin
          idx_d = idx_q + CNT_W'(1);
        end
      end
      ST_SYNC: begin
        if (ev_ready) begin
          prev_en = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      new_cnt_q  <= '0;
      prev_cnt_q <= '0;
      new_q      <= '0;
      prev_q     <= '0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      new_cnt_q <= new_cnt_d;
      if (new_en) new_q <= dec_codes;
      if (prev_en) begin
        prev_q     <= new_q;
        prev_cnt_q <= new_cnt_q;
      end
    end
  end

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_code) && $stable(ev_press) && $stable(ev_sync)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snap_ready |-> !ev_valid);

  p_sync_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_sync && ev_ready) |=> (idle && !ev_valid));

  p_no_release_after_press_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_press) |=> !(ev_valid && !ev_press && !ev_sync));
endmodule

// File: rtl/key_event_differ.sv
module key_event_differ #(
  parameter int NUM_ENT  = 8,
  parameter int NUM_ROWS = 16,
  parameter int NUM_COLS = 8,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int COL_W   = $clog2(NUM_COLS),
  localparam int CODE_W  = ROW_W + COL_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fn_mode_en,
  input  logic [CODE_W-1:0]          fn_code,
  input  logic                       ghost_en,
  input  logic                       snap_valid,
  output logic                       snap_ready,
  input  logic [NUM_ENT-1:0]         snap_vld,
  input  logic [NUM_ENT*ROW_W-1:0]   snap_row,
  input  logic [NUM_ENT*COL_W-1:0]   snap_col,
  input  logic                       rel_all,
  output logic                       ev_valid,
  input  logic                       ev_ready,
  output logic                       ev_press,
  output logic                       ev_sync,
  output logic [CODE_W-1:0]          ev_code
);
  localparam int KEY_CNT = (1 << ROW_W) * (1 << COL_W);
  localparam int CNT_W   = $clog2(NUM_ENT + 1);

  logic                           rst_meta, rst_sync;
  logic [NUM_ENT-1:0][CODE_W-1:0] dec_codes;
  logic [CNT_W-1:0]               dec_cnt;
  logic                           fn_hit, ghost;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  kef_snap_decode #(
    .NUM_ENT(NUM_ENT), .ROW_W(ROW_W), .COL_W(COL_W),
    .CODE_W(CODE_W), .KEY_CNT(KEY_CNT), .CNT_W(CNT_W)
  ) u_decode (
    .clk(clk), .rst_n(rst_sync),
    .ent_vld(snap_vld), .ent_row(snap_row), .ent_col(snap_col),
    .fn_en(fn_mode_en), .fn_code(fn_code),
    .codes(dec_codes), .cnt(dec_cnt), .fn_hit(fn_hit)
  );

  kef_ghost_check #(
    .NUM_ENT(NUM_ENT), .COL_W(COL_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) u_ghost (
    .clk(clk), .rst_n(rst_sync), .en(ghost_en),
    .codes(dec_codes), .cnt(dec_cnt), .ghost(ghost)
  );

  kef_event_seq #(
    .NUM_ENT(NUM_ENT), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync),
    .snap_valid(snap_valid), .rel_all(rel_all),
    .dec_codes(dec_codes), .dec_cnt(dec_cnt), .ghost(ghost),
    .snap_ready(snap_ready),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_press(ev_press), .ev_sync(ev_sync), .ev_code(ev_code)
  );

  p_fn_only_in_mode_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    !fn_mode_en |-> !fn_hit);
endmodule

// File: tb/tb_key_event_differ.sv
module tb_key_event_differ;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fn_mode_en, ghost_en, snap_valid, rel_all, ev_ready;
  logic [7:0]  fn_code;
  logic [7:0]  snap_vld;
  logic [31:0] snap_row;
  logic [23:0] snap_col;
  logic        snap_ready, ev_valid, ev_press, ev_sync;
  logic [7:0]  ev_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit bp      = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  int l_code[64]; bit l_press[64]; bit l_sync[64]; int l_n = 0;
  int e_code[64]; bit e_press[64]; bit e_sync[64]; int e_n = 0;
  int m_prev[8]; int m_cnt = 0;

  always #5 clk = ~clk;

  key_event_differ dut (
    .clk(clk), .rst_n(rst_n), .fn_mode_en(fn_mode_en), .fn_code(fn_code),
    .ghost_en(ghost_en), .snap_valid(snap_valid), .snap_ready(snap_ready),
    .snap_vld(snap_vld), .snap_row(snap_row), .snap_col(snap_col),
    .rel_all(rel_all), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_press(ev_press), .ev_sync(ev_sync), .ev_code(ev_code)
  );

  // Event logger and consumer back-pressure, away from the rising edge
  always @(negedge clk) begin
    if (ev_valid && ev_ready && l_n < 64) begin
      l_code[l_n]  = int'(ev_code);
      l_press[l_n] = ev_press;
      l_sync[l_n]  = ev_sync;
      l_n++;
    end
    lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ev_ready = bp ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    l_n = 0;
    e_n = 0;
  endtask

  task automatic push_exp(input bit p, input int c, input bit s);
    e_press[e_n] = p; e_code[e_n] = c; e_sync[e_n] = s; e_n++;
  endtask

  // Bench model of the requirements
  task automatic model_snap(input logic [7:0] v, input logic [31:0] r,
                            input logic [23:0] c, input bit fe, input int fc,
                            input bit ge);
    int nc[8]; int n = 0; bit fh = 0; bit sc = 0; bit sr = 0;
    for (int k = 0; k < 8; k++) begin
      if (v[k]) begin
        int code;
        code = int'(r[4*k +: 4]) * 8 + int'(c[3*k +: 3]);   // R1
        if (fe && code == fc) fh = 1;                        // R2
        else begin nc[n] = code; n++; end
      end
    end
    if (fh) for (int k = 0; k < n; k++) nc[k] += 128;
    if (ge && n >= 3) begin                                  // R4
      for (int i = 0; i < n; i++)
        for (int j = i + 1; j < n; j++) begin
          if (nc[i] % 8 == nc[j] % 8) sc = 1;
          if (nc[i] / 8 == nc[j] / 8) sr = 1;
        end
      if (sc && sr) return;
    end
    for (int i = 0; i < m_cnt; i++) begin                    // R6
      bit found = 0;
      for (int j = 0; j < n; j++) if (nc[j] == m_prev[i]) found = 1;
      if (!found) push_exp(0, m_prev[i], 0);
    end
    for (int j = 0; j < n; j++) push_exp(1, nc[j], 0);      // R7
    push_exp(0, 0, 1);
    for (int j = 0; j < n; j++) m_prev[j] = nc[j];           // R8
    m_cnt = n;
  endtask

  task automatic model_rel_all();
    for (int i = 0; i < m_cnt; i++) push_exp(0, m_prev[i], 0);
    push_exp(0, 0, 1);
    m_cnt = 0;
  endtask

  task automatic compare(input string req);
    chk(l_n == e_n, req, "event count", l_n, e_n);
    for (int i = 0; i < l_n && i < e_n; i++)
      chk({l_sync[i], l_press[i], l_code[i][7:0]} == {e_sync[i], e_press[i], e_code[i][7:0]},
          req, $sformatf("event %0d {sync,press,code}", i),
          int'({l_sync[i], l_press[i], l_code[i][7:0]}),
          int'({e_sync[i], e_press[i], e_code[i][7:0]}));
  endtask

  task automatic wait_idle();
    int g = 0;
    while (!snap_ready && g < 2000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic hold_until_taken();
    int g = 0;
    #1;
    while (!snap_ready && g < 2000) begin @(negedge clk); #1; g++; end
    @(negedge clk);
    snap_valid = 1'b0;
    wait_idle();
  endtask

  task automatic push_snap(input logic [7:0] v, input logic [31:0] r,
                           input logic [23:0] c);
    @(negedge clk);
    snap_vld = v; snap_row = r; snap_col = c;
    snap_valid = 1'b1;
    model_snap(v, r, c, fn_mode_en, int'(fn_code), ghost_en);
    hold_until_taken();
  endtask

  // Scenarios
  task automatic t_reset();
    chk(snap_ready == 1'b1, "R11", "snap_ready after reset", int'(snap_ready), 1);
    chk(ev_valid == 1'b0, "R11", "ev_valid after reset", int'(ev_valid), 0);
  endtask

  task automatic t_basic();
    clear_logs();
    // slot0 r2c5 = 0x15, slot1 invalid, slot2 r10c1 = 0x51
    push_snap(8'b0000_0101, 32'h0000_0A02, 24'h00_0045);
    compare("R1");
    chk(l_n > 0 && l_code[0] == 8'h15, "R1", "first code row2 col5", l_n > 0 ? l_code[0] : -1, 8'h15);
    chk(l_n > 1 && l_code[1] == 8'h51, "R1", "invalid slot skipped", l_n > 1 ? l_code[1] : -1, 8'h51);
  endtask

  task automatic t_change_bp();
    clear_logs();
    bp = 1'b1;
    // slot0 r2c5 = 0x15, slot5 r0c0 = 0x00
    push_snap(8'b0010_0001, 32'h0000_0002, 24'h00_0005);
    bp = 1'b0;
    compare("R6 R10");
    chk(l_n > 0 && l_code[0] == 8'h51 && !l_press[0], "R6", "release first", l_n > 0 ? l_code[0] : -1, 8'h51);
  endtask

  task automatic t_ghost();
    ghost_en = 1'b1;
    clear_logs();
    // r1c1=0x09, r1c2=0x0A, r3c1=0x19
    push_snap(8'b0000_0111, 32'h0000_0311, 24'h00_0051);
    compare("R4");
    chk(l_n == 0, "R4", "ghost snapshot event count", l_n, 0);
    clear_logs();
    push_snap(8'h00, 32'h0, 24'h0);  // empty: releases prove set unchanged
    compare("R4 R8");
    clear_logs();
    // same row only: r1c1, r1c2, r1c3 -> accepted
    push_snap(8'b0000_0111, 32'h0000_0111, 24'h00_00D1);
    compare("R5");
    ghost_en = 1'b0;
    clear_logs();
    push_snap(8'b0000_0111, 32'h0000_0311, 24'h00_0051);
    compare("R5");
    chk(l_n == e_n && l_n > 0, "R5", "filter off accepts pattern", l_n, e_n);
  endtask

  task automatic t_fn();
    fn_mode_en = 1'b1;
    fn_code = 8'h7F;
    clear_logs();
    // slot0 r15c7 = 0x7F (function key), slot1 r2c5 = 0x15
    push_snap(8'b0000_0011, 32'h0000_002F, 24'h00_002F);
    compare("R2");
    chk(l_n >= 2 && l_code[l_n-2] == 8'h95 && l_press[l_n-2], "R2", "shifted press", l_n >= 2 ? l_code[l_n-2] : -1, 8'h95);
    fn_mode_en = 1'b0;
    clear_logs();
    push_snap(8'b0000_0011, 32'h0000_002F, 24'h00_002F);
    compare("R3");
  endtask

  task automatic t_collision();
    clear_logs();
    @(negedge clk);
    snap_vld = 8'b0000_0001; snap_row = 32'h3; snap_col = 24'h3;  // 0x1B
    rel_all = 1'b1;
    snap_valid = 1'b1;
    #1;
    chk(snap_ready == 1'b0, "R9", "snap_ready while rel_all", int'(snap_ready), 0);
    model_rel_all();
    model_snap(8'b0000_0001, 32'h3, 24'h3, 1'b0, 8'h7F, 1'b0);
    @(negedge clk);
    rel_all = 1'b0;
    hold_until_taken();
    compare("R9");
    chk(l_n > 2 && l_sync[2] && !l_press[1], "R9", "release-all sync before presses", l_n, e_n);
  endtask

  initial begin
    rst_n = 1'b0; fn_mode_en = 1'b0; ghost_en = 1'b0; snap_valid = 1'b0;
    rel_all = 1'b0; fn_code = 8'h7F; snap_vld = '0; snap_row = '0; snap_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_change_bp();
    t_ghost();
    t_fn();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10 watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule